// File: doc/BRIEF.md
# Page Write Sequencer with Busy Timer

This block collects the data bytes of a serial-memory write command into a page-sized buffer and, when chip select is released at a clean byte boundary, commits the received bytes to the storage array. While the commit runs, the block holds a busy flag for a fixed, parameterised number of clock ticks. At the end of that interval it asks the command engine to clear the write enable latch.

The command engine upstream decodes the opcode and the address. It pulses `seq_start` with the starting address, then strobes `byte_vld` once per complete data byte. When chip select goes high it pulses `cs_rise`, and at the same time it presents its bit counter (`bit_idx`), the write enable latch and a protection verdict for the target page.

The block keeps only the high part of the address fixed. The in-page offset advances after every byte and wraps inside the page, so a later byte overwrites an earlier one. A per-byte valid mask records which offsets were received. During the busy interval, the first `PAGE` ticks scan the offsets in ascending order, and the block emits one array write strobe for each valid offset. `CYCLE_TICKS` must be at least `2**PAGE_W`.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy`, `arr_we`, `done` and `wel_clr` are all 0.
- R2: Each byte accepted after `seq_start` is stored at the current in-page offset. On commit, the array receives it at address {page bits of `start_addr`, offset}.
- R3: The offset starts at the low `PAGE_W` bits of `start_addr`, adds one per byte and wraps modulo 2**`PAGE_W`. The upper address bits never change, and a byte that lands on an offset already filled replaces it.
- R4: A commit strobes `arr_we` exactly once for every offset that received at least one byte, and never for any other offset. Strobes come in ascending offset order.
- R5: A commit happens only if `wel`=1 at the `cs_rise` pulse. With `wel`=0 there is no strobe and `busy` stays 0.
- R6: A commit happens only if `wr_blocked`=0 at the `cs_rise` pulse. Otherwise nothing is written and `busy` stays 0.
- R7: If `bit_idx` is not 0 at the `cs_rise` pulse (a partial byte), the buffer is discarded and no cycle starts.
- R8: On commit, `busy` rises in the cycle after the `cs_rise` pulse and stays high for exactly `CYCLE_TICKS` cycles. All strobes fall inside that interval.
- R9: `done` and `wel_clr` are high together for exactly one cycle: the last cycle of the busy interval.
- R10: While `busy` is 1, `seq_start`, `byte_vld` and `cs_rise` have no effect. No extra strobes appear, and no second busy interval follows.
- R11: A `cs_rise` with no byte received since `seq_start` starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Write command decoded; latch the start address |
| start_addr | input | ADDR_W | First byte address of the write |
| byte_vld | input | 1 | One complete data byte received |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select went high |
| bit_idx | input | 3 | Bit count modulo 8 at the chip-select rise |
| wel | input | 1 | Write enable latch |
| wr_blocked | input | 1 | Target page is write protected |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| done | output | 1 | Last tick of the write cycle |
| wel_clr | output | 1 | Request to clear the write enable latch |

## Verification
The bench goes after offset wrap at the page edge and overruns longer than a page. A design that carried into the page bits would write into the neighbouring page, and one that dropped overwrites would strobe the stale byte. It releases chip select in the middle of a byte, with the latch clear, with the page protected and with no data, and expects no busy at all; a faulty commit condition would start a cycle that should never occur. It also sends a full second command while the cycle is running: a design that listened while busy would produce extra strobes or a second busy interval. It measures the busy length and the `done` and `wel_clr` pulses, which an off-by-one in the timer would stretch or shorten.

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int CYCLE_TICKS = 320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic [2:0]        bit_idx,
  input  logic              wel,
  input  logic              wr_blocked,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic              busy,
  output logic              done,
  output logic              wel_clr
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(CYCLE_TICKS + PAGE + 1);

  logic                     active;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0]        off_q;
  logic [PAGE-1:0]          vmask;
  logic [7:0]               pbuf [PAGE];
  logic                     busy_q;
  logic [CNT_W-1:0]         tick;

  wire idle      = !busy_q;
  wire take      = idle && active && byte_vld && !seq_start && !cs_rise;
  wire commit    = idle && active && cs_rise && wel && !wr_blocked &&
                   (bit_idx == 3'd0) && (|vmask);
  wire last_tick = busy_q && (tick == CNT_W'(CYCLE_TICKS - 1));
  wire [PAGE_W-1:0] scan = tick[PAGE_W-1:0];
  wire in_scan   = tick < CNT_W'(PAGE);

  assign arr_we   = busy_q && in_scan && vmask[scan];
  assign arr_addr = {page_q, scan};
  assign arr_data = pbuf[scan];
  assign busy     = busy_q;
  assign done     = last_tick;
  assign wel_clr  = last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      page_q <= '0;
      off_q  <= '0;
      vmask  <= '0;
      busy_q <= 1'b0;
      tick   <= '0;
    end else if (idle) begin
      if (seq_start) begin
        active <= 1'b1;
        page_q <= start_addr[ADDR_W-1:PAGE_W];
        off_q  <= start_addr[PAGE_W-1:0];
        vmask  <= '0;
      end else if (cs_rise) begin
        active <= 1'b0;
        if (commit) begin
          busy_q <= 1'b1;
          tick   <= '0;
        end else begin
          vmask <= '0;
        end
      end else if (take) begin
        vmask[off_q] <= 1'b1;
        off_q        <= off_q + 1'b1;
      end
    end else begin
      if (last_tick) begin
        busy_q <= 1'b0;
        vmask  <= '0;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[off_q] <= byte_data;
  end
endmodule

module page_write_seq_chk #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int CYCLE_TICKS = 320
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic [2:0]        bit_idx,
  input logic              wel,
  input logic              wr_blocked,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              busy,
  input logic              done
);
  logic [31:0]       run_len;
  logic              busy_d;
  logic              seen_we;
  logic [PAGE_W-1:0] last_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= '0;
      busy_d   <= 1'b0;
      seen_we  <= 1'b0;
      last_off <= '0;
    end else begin
      busy_d <= busy;
      if (busy && !busy_d) run_len <= 32'd1;
      else if (busy)       run_len <= run_len + 32'd1;
      if (!busy) seen_we <= 1'b0;
      else if (arr_we) begin
        seen_we  <= 1'b1;
        last_off <= arr_addr[PAGE_W-1:0];
      end
    end
  end

  AST_BUSY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && wel && !wr_blocked && bit_idx == 3'd0)); // R5
  AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy); // R8
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == 32'(CYCLE_TICKS)); // R8
  AST_DONE_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_d) |-> $stable(arr_addr[ADDR_W-1:PAGE_W])); // R3
  AST_STROBE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && seen_we) |-> arr_addr[PAGE_W-1:0] > last_off); // R4
endmodule

bind page_write_seq page_write_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_TICKS(CYCLE_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .bit_idx(bit_idx),
  .wel(wel), .wr_blocked(wr_blocked), .arr_we(arr_we),
  .arr_addr(arr_addr), .busy(busy), .done(done)
);

// File: tb/page_write_seq_tb.sv
module page_write_seq_tb;
  localparam int AW  = 14;
  localparam int PW  = 6;
  localparam int CYC = 80;
  localparam int PG  = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seq_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          byte_vld = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          cs_rise = 1'b0;
  logic [2:0]    bit_idx = '0;
  logic          wel = 1'b0;
  logic          wr_blocked = 1'b0;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_data;
  logic          busy, done, wel_clr;

  page_write_seq #(.ADDR_W(AW), .PAGE_W(PW), .CYCLE_TICKS(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .bit_idx(bit_idx), .wel(wel), .wr_blocked(wr_blocked), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy), .done(done),
    .wel_clr(wel_clr)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int log_n, done_cnt, clr_cnt, busy_runs, cur_run, last_run, cycles = 0;
  logic [AW-1:0] log_addr [256];
  logic [7:0]    log_data [256];

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (arr_we && log_n < 256) begin
        log_addr[log_n] = arr_addr;
        log_data[log_n] = arr_data;
        log_n++;
      end
      if (done) done_cnt++;
      if (wel_clr) clr_cnt++;
      if (busy) cur_run++;
      else if (cur_run != 0) begin
        busy_runs++;
        last_run = cur_run;
        cur_run  = 0;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0; done_cnt = 0; clr_cnt = 0; busy_runs = 0; cur_run = 0; last_run = 0;
  endtask

  task automatic send_seq(input logic [AW-1:0] addr, input int n, input logic [7:0] seed,
                          input bit wel_v, input bit blk_v, input logic [2:0] phase);
    @(negedge clk);
    seq_start = 1'b1; start_addr = addr;
    @(negedge clk);
    seq_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_data = seed + 8'(i);
      @(negedge clk);
    end
    byte_vld = 1'b0;
    cs_rise = 1'b1; bit_idx = phase; wel = wel_v; wr_blocked = blk_v;
    @(negedge clk);
    cs_rise = 1'b0; bit_idx = '0; wel = 1'b0; wr_blocked = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (CYC + 4) @(negedge clk);
  endtask

  task automatic verify_log(input string tag, input logic [AW-1:0] addr, input int n,
                            input logic [7:0] seed);
    bit         ev [PG];
    logic [7:0] ed [PG];
    int cnt = 0, k = 0;
    for (int j = 0; j < PG; j++) ev[j] = 1'b0;
    for (int i = 0; i < n; i++) begin
      int o = (int'(addr[PW-1:0]) + i) % PG;
      ev[o] = 1'b1; ed[o] = seed + 8'(i);
    end
    for (int j = 0; j < PG; j++) if (ev[j]) cnt++;
    chk(log_n == cnt, {tag, " R4 strobe count"}, log_n, cnt);
    for (int j = 0; j < PG; j++) begin
      if (ev[j] && k < log_n) begin
        logic [AW-1:0] ea = {addr[AW-1:PW], PW'(j)};
        chk(log_addr[k] == ea, {tag, " R3 strobe addr"}, int'(log_addr[k]), int'(ea));
        chk(log_data[k] == ed[j], {tag, " R2 strobe data"}, int'(log_data[k]), int'(ed[j]));
        k++;
      end
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
    chk(done == 1'b0 && wel_clr == 1'b0, "R1 done/wel_clr", {done, wel_clr}, 0);
  endtask

  task automatic t_basic();
    clear_log();
    send_seq(14'h0123, 4, 8'hA0, 1, 0, 3'd0);
    chk(busy == 1'b1, "R8 busy after cs rise", busy, 1);
    wait_idle();
    verify_log("basic", 14'h0123, 4, 8'hA0);
    chk(busy_runs == 1 && last_run == CYC, "R8 busy length", last_run, CYC);
    chk(done_cnt == 1, "R9 done pulses", done_cnt, 1);
    chk(clr_cnt == 1, "R9 wel_clr pulses", clr_cnt, 1);
  endtask

  task automatic t_wrap_edge();
    clear_log();
    send_seq(14'h1A7E, 5, 8'h10, 1, 0, 3'd0);
    wait_idle();
    verify_log("wrap edge", 14'h1A7E, 5, 8'h10);
  endtask

  task automatic t_overrun();
    clear_log();
    send_seq(14'h2C80, PG + 3, 8'h00, 1, 0, 3'd0);
    wait_idle();
    verify_log("overrun R3", 14'h2C80, PG + 3, 8'h00);
  endtask

  task automatic t_no_wel();
    clear_log();
    send_seq(14'h0200, 3, 8'h55, 0, 0, 3'd0);
    chk(busy == 1'b0, "R5 busy with wel clear", busy, 0);
    wait_idle();
    chk(log_n == 0 && busy_runs == 0, "R5 no strobes", log_n, 0);
  endtask

  task automatic t_blocked();
    clear_log();
    send_seq(14'h3F00, 3, 8'h66, 1, 1, 3'd0);
    chk(busy == 1'b0, "R6 busy when blocked", busy, 0);
    wait_idle();
    chk(log_n == 0 && busy_runs == 0, "R6 no strobes", log_n, 0);
  endtask

  task automatic t_partial();
    clear_log();
    send_seq(14'h0100, 3, 8'h77, 1, 0, 3'd3);
    chk(busy == 1'b0, "R7 busy on partial byte", busy, 0);
    wait_idle();
    chk(log_n == 0 && busy_runs == 0, "R7 no strobes", log_n, 0);
    clear_log();
    send_seq(14'h0105, 1, 8'h88, 1, 0, 3'd0);
    wait_idle();
    verify_log("after partial R7", 14'h0105, 1, 8'h88);
  endtask

  task automatic t_empty();
    clear_log();
    send_seq(14'h0400, 0, 8'h00, 1, 0, 3'd0);
    chk(busy == 1'b0, "R11 busy with no bytes", busy, 0);
    wait_idle();
    chk(busy_runs == 0, "R11 no cycle", busy_runs, 0);
  endtask

  task automatic t_ignore_busy();
    clear_log();
    send_seq(14'h0040, 5, 8'hC0, 1, 0, 3'd0);
    send_seq(14'h0200, 3, 8'hE0, 1, 0, 3'd0);
    wait_idle();
    verify_log("ignore R10", 14'h0040, 5, 8'hC0);
    chk(busy_runs == 1, "R10 single busy run", busy_runs, 1);
    chk(last_run == CYC, "R10 run length", last_run, CYC);
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap_edge();
    t_overrun();
    t_no_wel();
    t_blocked();
    t_partial();
    t_empty();
    t_ignore_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule